// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This unit executes the integer arithmetic operate group of a 64-bit load/store processor. Each cycle it takes a 32-bit instruction word and the two source register values already read from the register file. It returns the value to write back, the destination register index, a write strobe and a flag for an unimplemented function code. The supported operations are add and subtract on full 64-bit quadwords and on 32-bit longwords, add and subtract with the first operand pre-multiplied by 4 or 8, and equality, signed and unsigned comparisons.

The second operand is either the register value or an 8-bit unsigned literal held in the instruction. One instruction bit chooses between them. All outputs are registered, so a result appears one clock edge after its inputs are applied. Register 31 is the hardwired zero register. The register file is expected to present zero when it is read, and a write aimed at it is dropped.

Top module: `int_arith_unit`

## Requirements
- R1: While `rst_n` is low, `res_o`, `dest_o`, `wr_en_o` and `bad_func_o` are all zero.
- R2: Inputs present before a rising clock edge determine the outputs from that edge on, and the outputs hold until the next edge.
- R3: When instruction bit 12 is 1, the second operand is instruction bits 20:13, zero-extended, and `opnd_b` is ignored. When bit 12 is 0, the second operand is `opnd_b`.
- R4: Function code 0x20 gives A+B and 0x29 gives A-B, both modulo 2^64. The function code is instruction bits 11:5.
- R5: Scaled forms shift A left before the add or subtract. The shift is by 2 for codes 0x22 (add), 0x2b (sub), 0x02 (add, long) and 0x0b (sub, long). It is by 3 for codes 0x32 (add), 0x3b (sub), 0x12 (add, long) and 0x1b (sub, long).
- R6: Longword codes 0x00 (add), 0x09 (sub), 0x02, 0x0b, 0x12 and 0x1b keep bits 31:0 of the result and sign-extend bit 31 into bits 63:32.
- R7: Compare codes write 1 when the condition holds and 0 otherwise. The codes are 0x2d (A==B), 0x1d (A<B unsigned), 0x3d (A<=B unsigned), 0x4d (A<B signed) and 0x6d (A<=B signed).
- R8: `dest_o` always carries instruction bits 4:0. `wr_en_o` is 1 only when all three of these hold: the opcode in bits 31:26 is 0x10, the function code is one of the listed ones, and the destination is not 31.
- R9: When the destination is 31, `wr_en_o` and `bad_func_o` are both 0 and `res_o` is 0, whatever the function code.
- R10: An unlisted function code with opcode 0x10 and a destination other than 31 sets `bad_func_o`. In that case `wr_en_o` is 0 and `res_o` is 0.
- R11: An opcode other than 0x10 gives `wr_en_o`=0, `bad_func_o`=0 and `res_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | 32 | Instruction word |
| opnd_a | input | 64 | First source register value |
| opnd_b | input | 64 | Second source register value |
| res_o | output | 64 | Write-back value |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back strobe |
| bad_func_o | output | 1 | Unimplemented function code |

## Verification
Every output comes from a single register stage. A vector applied at a falling edge is therefore due at the next rising edge, and the bench reads it at the falling edge after that, half a period clear of the update. One directed check reads the outputs just before the capturing edge and again after it, to confirm the one-edge delay. The sweep covers all 128 function codes in both operand modes and against corner operand values, and it changes the inputs only at falling edges.

// File: rtl/iau_pkg.sv
package iau_pkg;

    localparam int FUNC_W = 7;

    localparam logic [FUNC_W-1:0] FN_ADDL   = 7'h00;
    localparam logic [FUNC_W-1:0] FN_S4ADDL = 7'h02;
    localparam logic [FUNC_W-1:0] FN_SUBL   = 7'h09;
    localparam logic [FUNC_W-1:0] FN_S4SUBL = 7'h0b;
    localparam logic [FUNC_W-1:0] FN_S8ADDL = 7'h12;
    localparam logic [FUNC_W-1:0] FN_S8SUBL = 7'h1b;
    localparam logic [FUNC_W-1:0] FN_CMPULT = 7'h1d;
    localparam logic [FUNC_W-1:0] FN_ADDQ   = 7'h20;
    localparam logic [FUNC_W-1:0] FN_S4ADDQ = 7'h22;
    localparam logic [FUNC_W-1:0] FN_SUBQ   = 7'h29;
    localparam logic [FUNC_W-1:0] FN_S4SUBQ = 7'h2b;
    localparam logic [FUNC_W-1:0] FN_CMPEQ  = 7'h2d;
    localparam logic [FUNC_W-1:0] FN_S8ADDQ = 7'h32;
    localparam logic [FUNC_W-1:0] FN_S8SUBQ = 7'h3b;
    localparam logic [FUNC_W-1:0] FN_CMPULE = 7'h3d;
    localparam logic [FUNC_W-1:0] FN_CMPLT  = 7'h4d;
    localparam logic [FUNC_W-1:0] FN_CMPLE  = 7'h6d;

    typedef enum logic [1:0] {
        OPK_ADD = 2'd0,
        OPK_SUB = 2'd1,
        OPK_CMP = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_ULT = 3'd1,
        CMP_ULE = 3'd2,
        CMP_SLT = 3'd3,
        CMP_SLE = 3'd4
    } cmp_kind_e;

    typedef struct packed {
        logic      legal;
        op_kind_e  kind;
        logic [1:0] shamt;
        logic      lword;
        cmp_kind_e cmp;
    } fdec_t;

endpackage

// File: rtl/iau_decode.sv
module iau_decode
    import iau_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output fdec_t             dec_o
);

    always_comb begin
        dec_o       = '0;
        dec_o.legal = 1'b1;
        dec_o.kind  = OPK_ADD;
        dec_o.cmp   = CMP_EQ;
        unique case (func_i)
            FN_ADDL:   begin dec_o.lword = 1'b1; end
            FN_S4ADDL: begin dec_o.lword = 1'b1; dec_o.shamt = 2'd2; end
            FN_S8ADDL: begin dec_o.lword = 1'b1; dec_o.shamt = 2'd3; end
            FN_SUBL:   begin dec_o.lword = 1'b1; dec_o.kind = OPK_SUB; end
            FN_S4SUBL: begin dec_o.lword = 1'b1; dec_o.kind = OPK_SUB; dec_o.shamt = 2'd2; end
            FN_S8SUBL: begin dec_o.lword = 1'b1; dec_o.kind = OPK_SUB; dec_o.shamt = 2'd3; end
            FN_ADDQ:   begin end
            FN_S4ADDQ: begin dec_o.shamt = 2'd2; end
            FN_S8ADDQ: begin dec_o.shamt = 2'd3; end
            FN_SUBQ:   begin dec_o.kind = OPK_SUB; end
            FN_S4SUBQ: begin dec_o.kind = OPK_SUB; dec_o.shamt = 2'd2; end
            FN_S8SUBQ: begin dec_o.kind = OPK_SUB; dec_o.shamt = 2'd3; end
            FN_CMPEQ:  begin dec_o.kind = OPK_CMP; dec_o.cmp = CMP_EQ;  end
            FN_CMPULT: begin dec_o.kind = OPK_CMP; dec_o.cmp = CMP_ULT; end
            FN_CMPULE: begin dec_o.kind = OPK_CMP; dec_o.cmp = CMP_ULE; end
            FN_CMPLT:  begin dec_o.kind = OPK_CMP; dec_o.cmp = CMP_SLT; end
            FN_CMPLE:  begin dec_o.kind = OPK_CMP; dec_o.cmp = CMP_SLE; end
            default:   begin dec_o.legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/iau_opsel.sv
module iau_opsel #(
    parameter int DATA_W  = 64,
    parameter int INSN_W  = 32,
    parameter int LIT_W   = 8,
    parameter int LIT_LSB = 13,
    parameter int SEL_BIT = 12
) (
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] reg_b_i,
    output logic [DATA_W-1:0] b_eff_o
);

    localparam int LIT_MSB = LIT_LSB + LIT_W - 1;
    localparam int PAD_W   = DATA_W - LIT_W;

    logic [DATA_W-1:0] lit_ext;

    assign lit_ext = {{PAD_W{1'b0}}, insn_i[LIT_MSB:LIT_LSB]};

    always_comb begin
        if (insn_i[SEL_BIT]) begin
            b_eff_o = lit_ext;
        end else begin
            b_eff_o = reg_b_i;
        end
    end

endmodule

// File: rtl/iau_addsub.sv
module iau_addsub #(
    parameter int DATA_W  = 64,
    parameter int LONG_W  = 32,
    parameter int SHAMT_W = 2
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic               sub_i,
    input  logic               lword_i,
    output logic [DATA_W-1:0]  sum_o
);

    localparam int N_SHIFT = 1 << SHAMT_W;
    localparam int EXT_W   = DATA_W - LONG_W;

    logic [DATA_W-1:0] scaled [N_SHIFT];
    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] raw;

    for (genvar s = 0; s < N_SHIFT; s++) begin : g_scale
        assign scaled[s] = a_i << s;
    end

    assign a_sc = scaled[shamt_i];

    always_comb begin
        if (sub_i) begin
            raw = a_sc - b_i;
        end else begin
            raw = a_sc + b_i;
        end
        if (lword_i) begin
            sum_o = {{EXT_W{raw[LONG_W-1]}}, raw[LONG_W-1:0]};
        end else begin
            sum_o = raw;
        end
    end

endmodule

// File: rtl/iau_compare.sv
module iau_compare
    import iau_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  cmp_kind_e         kind_i,
    output logic              hit_o
);

    logic eq, ult, slt;

    assign eq  = (a_i == b_i);
    assign ult = (a_i < b_i);
    assign slt = ($signed(a_i) < $signed(b_i));

    always_comb begin
        unique case (kind_i)
            CMP_EQ:  hit_o = eq;
            CMP_ULT: hit_o = ult;
            CMP_ULE: hit_o = ult | eq;
            CMP_SLT: hit_o = slt;
            CMP_SLE: hit_o = slt | eq;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
    import iau_pkg::*;
#(
    parameter int              DATA_W    = 64,
    parameter int              LONG_W    = 32,
    parameter int              LIT_W     = 8,
    parameter int              RIDX_W    = 5,
    parameter logic [5:0]      GROUP_OPC = 6'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_o,
    output logic [RIDX_W-1:0] dest_o,
    output logic              wr_en_o,
    output logic              bad_func_o
);

    localparam int INSN_W   = 32;
    localparam int OPC_W    = 6;
    localparam int OPC_LSB  = INSN_W - OPC_W;
    localparam int FUNC_LSB = RIDX_W;
    localparam int FUNC_MSB = FUNC_LSB + FUNC_W - 1;
    localparam int SEL_BIT  = FUNC_MSB + 1;
    localparam int LIT_LSB  = SEL_BIT + 1;
    localparam logic [RIDX_W-1:0] ZERO_REG = '1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [RIDX_W-1:0] dest;
        logic              we;
        logic              fault;
    } out_t;

    out_t out_d, out_q;

    fdec_t             dec;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic              hit;
    logic              opc_ok;
    logic              to_zero;
    logic [RIDX_W-1:0] rc;

    assign rc      = instr_word[RIDX_W-1:0];
    assign opc_ok  = (instr_word[INSN_W-1:OPC_LSB] == GROUP_OPC);
    assign to_zero = (rc == ZERO_REG);

    iau_decode u_decode (
        .func_i (instr_word[FUNC_MSB:FUNC_LSB]),
        .dec_o  (dec)
    );

    iau_opsel #(
        .DATA_W  (DATA_W),
        .INSN_W  (INSN_W),
        .LIT_W   (LIT_W),
        .LIT_LSB (LIT_LSB),
        .SEL_BIT (SEL_BIT)
    ) u_opsel (
        .insn_i  (instr_word),
        .reg_b_i (opnd_b),
        .b_eff_o (b_eff)
    );

    iau_addsub #(
        .DATA_W  (DATA_W),
        .LONG_W  (LONG_W),
        .SHAMT_W (2)
    ) u_addsub (
        .a_i     (opnd_a),
        .b_i     (b_eff),
        .shamt_i (dec.shamt),
        .sub_i   (dec.kind == OPK_SUB),
        .lword_i (dec.lword),
        .sum_o   (sum)
    );

    iau_compare #(
        .DATA_W (DATA_W)
    ) u_compare (
        .a_i    (opnd_a),
        .b_i    (b_eff),
        .kind_i (dec.cmp),
        .hit_o  (hit)
    );

    always_comb begin
        out_d      = '0;
        out_d.dest = rc;
        if (opc_ok && !to_zero) begin
            if (dec.legal) begin
                out_d.we = 1'b1;
                if (dec.kind == OPK_CMP) begin
                    out_d.res = {{(DATA_W-1){1'b0}}, hit};
                end else begin
                    out_d.res = sum;
                end
            end else begin
                out_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o      = out_q.res;
    assign dest_o     = out_q.dest;
    assign wr_en_o    = out_q.we;
    assign bad_func_o = out_q.fault;

endmodule

// File: rtl/int_arith_unit_chk.sv
module int_arith_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_word,
    input logic [63:0] res_o,
    input logic [4:0]  dest_o,
    input logic        wr_en_o,
    input logic        bad_func_o
);

    logic       past_ok_q;
    logic [6:0] fn;
    logic       in_group;
    logic       is_cmp;
    logic       is_long;

    assign fn       = instr_word[11:5];
    assign in_group = (instr_word[31:26] == 6'h10);
    assign is_cmp   = in_group && (fn == 7'h1d || fn == 7'h2d || fn == 7'h3d ||
                                   fn == 7'h4d || fn == 7'h6d);
    assign is_long  = in_group && (fn == 7'h00 || fn == 7'h02 || fn == 7'h09 ||
                                   fn == 7'h0b || fn == 7'h12 || fn == 7'h1b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_clear_r1: assert (res_o == '0 && dest_o == '0 && !wr_en_o && !bad_func_o)
                else $error("outputs not cleared in reset");
        end
    end

    p_dest_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> dest_o == $past(instr_word[4:0]));

    p_fault_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, bad_func_o}));

    p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dest_o == 5'd31 |-> (!wr_en_o && !bad_func_o && res_o == '0));

    p_cmp_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(is_cmp)) |-> res_o[63:1] == '0);

    p_long_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(is_long)) |-> res_o[63:32] == {32{res_o[31]}});

    p_other_opc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(in_group)) |-> (!wr_en_o && !bad_func_o && res_o == '0));

endmodule

bind int_arith_unit int_arith_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_word (instr_word),
    .res_o      (res_o),
    .dest_o     (dest_o),
    .wr_en_o    (wr_en_o),
    .bad_func_o (bad_func_o)
);

// File: tb/test_int_arith_unit.sv
module test_int_arith_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_word = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] res_o;
    logic [4:0]  dest_o;
    logic        wr_en_o;
    logic        bad_func_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [63:0] pats [8];

    always #5 clk = ~clk;

    int_arith_unit i_int_arith_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_word (instr_word),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .res_o      (res_o),
        .dest_o     (dest_o),
        .wr_en_o    (wr_en_o),
        .bad_func_o (bad_func_o)
    );

    function automatic string tag_of(input logic [5:0] opc, input logic [6:0] f,
                                     input logic [4:0] rc);
        if (opc != 6'h10) return "R11";
        if (rc == 5'd31) return "R9";
        case (f)
            7'h20, 7'h29: return "R4";
            7'h22, 7'h2b, 7'h32, 7'h3b: return "R5";
            7'h00, 7'h09, 7'h02, 7'h0b, 7'h12, 7'h1b: return "R6";
            7'h2d, 7'h1d, 7'h3d, 7'h4d, 7'h6d: return "R7";
            default: return "R10";
        endcase
    endfunction

    // reference model written from the requirements (R3..R11)
    task automatic model(input logic [31:0] iw, input logic [63:0] a, input logic [63:0] breg,
                         output logic [63:0] r, output logic we, output logic flt);
        logic [63:0] b, sa, t;
        logic [6:0]  f;
        logic        lg, sub, lng, cmp, c;
        int          sh;
        f   = iw[11:5];
        b   = iw[12] ? {56'd0, iw[20:13]} : breg;
        r   = '0; we = 1'b0; flt = 1'b0;
        lg  = 1'b1; sub = 1'b0; lng = 1'b0; cmp = 1'b0; c = 1'b0; sh = 0;
        case (f)
            7'h00: lng = 1;
            7'h02: begin lng = 1; sh = 2; end
            7'h12: begin lng = 1; sh = 3; end
            7'h09: begin lng = 1; sub = 1; end
            7'h0b: begin lng = 1; sub = 1; sh = 2; end
            7'h1b: begin lng = 1; sub = 1; sh = 3; end
            7'h20: ;
            7'h22: sh = 2;
            7'h32: sh = 3;
            7'h29: sub = 1;
            7'h2b: begin sub = 1; sh = 2; end
            7'h3b: begin sub = 1; sh = 3; end
            7'h2d: begin cmp = 1; c = (a == b); end
            7'h1d: begin cmp = 1; c = (a < b); end
            7'h3d: begin cmp = 1; c = (a <= b); end
            7'h4d: begin cmp = 1; c = ($signed(a) < $signed(b)); end
            7'h6d: begin cmp = 1; c = ($signed(a) <= $signed(b)); end
            default: lg = 0;
        endcase
        if (iw[31:26] != 6'h10 || iw[4:0] == 5'd31) return;
        if (!lg) begin flt = 1'b1; return; end
        we = 1'b1;
        sa = a * (64'd1 << sh);
        t  = sub ? sa - b : sa + b;
        if (lng) t = {{32{t[31]}}, t[31:0]};
        r  = cmp ? {63'd0, c} : t;
    endtask

    task automatic apply_check(input logic [31:0] iw, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] er;
        logic        ew, ef;
        string       tg;
        @(negedge clk);
        instr_word = iw; opnd_a = a; opnd_b = b;
        model(iw, a, b, er, ew, ef);
        tg = tag_of(iw[31:26], iw[11:5], iw[4:0]);
        if (iw[12] && tg != "R9" && tg != "R10" && tg != "R11") tg = {tg, "/R3"};
        @(negedge clk);
        n_vec++;
        if (res_o !== er || wr_en_o !== ew || bad_func_o !== ef || dest_o !== iw[4:0]) begin
            n_fail++;
            $display("FAIL %s (R8) iw=%h a=%h b=%h: got res=%h we=%b flt=%b dst=%0d, expected res=%h we=%b flt=%b dst=%0d",
                     tg, iw, a, b, res_o, wr_en_o, bad_func_o, dest_o, er, ew, ef, iw[4:0]);
        end
    endtask

    initial begin
        pats[0] = 64'h0;
        pats[1] = 64'h1;
        pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[3] = 64'h0000_0000_7FFF_FFFF;
        pats[4] = 64'h0000_0000_8000_0000;
        pats[5] = 64'h8000_0000_0000_0000;
        pats[6] = 64'h0123_4567_89AB_CDEF;
        pats[7] = 64'hFFFF_FFFF_0000_0001;

        // R1: reset state
        repeat (3) @(negedge clk);
        n_vec++;
        if (res_o !== '0 || dest_o !== '0 || wr_en_o !== 1'b0 || bad_func_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got res=%h dst=%0d we=%b flt=%b, expected all zero",
                     res_o, dest_o, wr_en_o, bad_func_o);
        end
        rst_n = 1'b1;

        // R2: one-edge latency, ADDQ 3+4 into r1
        @(negedge clk);
        instr_word = {6'h10, 5'd0, 8'd0, 1'b0, 7'h20, 5'd1};
        opnd_a = 64'd3; opnd_b = 64'd4;
        #4;
        n_vec++;
        if (res_o !== 64'd0) begin
            n_fail++;
            $display("FAIL R2 before edge: got %h expected %h", res_o, 64'd0);
        end
        @(negedge clk);
        n_vec++;
        if (res_o !== 64'd7 || wr_en_o !== 1'b1) begin
            n_fail++;
            $display("FAIL R2 after edge: got res=%h we=%b expected res=%h we=1", res_o, wr_en_o, 64'd7);
        end

        // R3..R10: sweep every function code, both operand modes, operand corners
        for (int f = 0; f < 128; f++) begin
            for (int lit = 0; lit < 2; lit++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        logic [7:0]  lv;
                        logic [4:0]  rc;
                        logic [31:0] iw;
                        lv = 8'(pats[j][7:0] + 8'(i * 37));
                        rc = 5'((f + i + j) % 32);
                        iw = {6'h10, 5'd0, lv, 1'(lit), 7'(f), rc};
                        apply_check(iw, pats[i], lit != 0 ? ~pats[j] : pats[j]);
                    end
                end
            end
        end

        // R11: foreign opcodes never write or fault
        for (int op = 0; op < 64; op++) begin
            if (op != 16) begin
                apply_check({6'(op), 5'd2, 8'h00, 1'b0, 7'h20, 5'd3}, pats[6], pats[1]);
                apply_check({6'(op), 5'd2, 8'h00, 1'b0, 7'h7f, 5'd4}, pats[6], pats[1]);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule